// File: doc/BRIEF.md
# Split-Port Burst-Four Double-Rate RAM

This block is a small synchronous memory with one port for reads and a separate port for writes. Both ports can be busy at once. Every access moves a burst of four words. Data travels on both halves of each command cycle, and this is modelled with a single beat clock that runs at twice the command rate. A command cycle is two beats long. The first beat after reset is beat 0, and the beats then alternate 0, 1, 0, 1.

The two port selects are sampled on beat 0 of a command cycle. One shared address bus carries the read burst address on beat 0 and the write burst address on beat 1. Write words arrive on their own input bus, one word per beat. Read words leave on their own output bus together with a valid flag. The read latency can be set to 1.5 or 1.0 command cycles.

The memory is split into four banks, one for each word position in a burst. A write is committed to all four banks in a single beat, once its last word has arrived. A read that follows a write still in flight is served from the captured write words, so it always returns the newest data.

Top module: `splitport_burst_ram`

## Requirements
- R1: While `rst` is high, and after it falls, `rvalid` is 0 and `rdata` is 0. Reset does not clear the memory contents.
- R2: Beats alternate starting with beat 0 at the first rising edge with `rst` low. The selects and the read address are sampled only on beat 0, and the write address only on beat 1.
- R3: A write sampled at beat E takes word k from `wdata` at beat E+k, for k = 0..3. Word k is stored at word location (burst address * 4 + k). It is committed at beat E+4, after all four words have been taken.
- R4: A read returns the four words of its burst in word order 0, 1, 2, 3 on four consecutive beats, with `rvalid` high for exactly those beats.
- R5: With `lat_mode` = 1, word 0 of a read sampled at beat R is driven on the edge of beat R+3. With `lat_mode` = 0, it is driven on the edge of beat R+2. `lat_mode` changes only while `rst` is high.
- R6: A select asserted in the second command cycle of its port's burst is ignored, together with its address. A select held low continuously is therefore accepted every other command cycle.
- R7: A read and a write can be sampled in the same command cycle, including to the same address. The read then returns the data that was there before that write.
- R8: A read sampled in the command cycle right after a write to the same burst address returns the new data, although the write is not yet committed.
- R9: `rdata` is 0 on every beat where `rvalid` is 0.
- R10: If `rst` rises before the fourth word of a write has been taken, that write is discarded and the old contents stay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Beat clock, two beats per command cycle |
| rst | input | 1 | Synchronous reset, active high |
| lat_mode | input | 1 | 1: read latency 1.5 command cycles; 0: 1.0 cycle |
| rd_sel_n | input | 1 | Read port select, active low, sampled on beat 0 |
| wr_sel_n | input | 1 | Write port select, active low, sampled on beat 0 |
| addr | input | AW | Burst address: read address on beat 0, write address on beat 1 |
| wdata | input | DW | Write word, one per beat |
| rdata | output | DW | Read word, one per beat, zero when idle |
| rvalid | output | 1 | High while `rdata` carries a read word |

## Verification
Isolated writes followed by spaced reads, run in both latency modes, separate the word ordering and the latency from the bank addressing. Holding a select low across several command cycles tells a port that ignores commands in the second cycle of its burst from one that restarts its burst. A read and a write to the same address in the same command cycle, and a read in the cycle after a write, tell the read-first rule apart from the forwarding path. A reset in the middle of a write burst, followed by a read, separates a discarded write from a committed one and also shows that the memory survives reset.

// File: rtl/sbr_pkg.sv
`timescale 1ns/1ps
package sbr_pkg;
  localparam int unsigned BURST = 4;
  typedef logic [1:0] beat_t;
endpackage

// File: rtl/sbr_bank.sv
`timescale 1ns/1ps
module sbr_bank #(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [DW-1:0] wd,
  input  logic          re,
  input  logic [AW-1:0] ra,
  output logic [DW-1:0] q
);
  localparam int ROWS = 1 << AW;

  logic [DW-1:0] mem [ROWS];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
  end

  always_ff @(posedge clk) begin
    if (re) q <= mem[ra];
  end
endmodule

// File: rtl/sbr_wr_capture.sv
`timescale 1ns/1ps
module sbr_wr_capture import sbr_pkg::*; #(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      acc,
  input  logic [AW-1:0]             addr,
  input  logic [DW-1:0]             wdata,
  output logic                      busy,
  output logic                      commit,
  output logic [AW-1:0]             base,
  output logic [BURST-1:0][DW-1:0]  words,
  output logic                      fwd_ok,
  output logic [BURST-1:0][DW-1:0]  fwd_words
);
  localparam beat_t LAST = beat_t'(BURST - 1);

  beat_t beat;
  logic  act;

  // Control: beat counter and one-beat commit pulse after the last word.
  always_ff @(posedge clk) begin
    if (rst) begin
      act    <= 1'b0;
      beat   <= '0;
      commit <= 1'b0;
    end else begin
      commit <= act && (beat == LAST);
      if (acc) begin
        act  <= 1'b1;
        beat <= beat_t'(1);
      end else if (act) begin
        beat <= beat + beat_t'(1);
        if (beat == LAST) act <= 1'b0;
      end
    end
  end

  // Data staging, no reset needed.
  always_ff @(posedge clk) begin
    if (acc) words[0] <= wdata;
    else if (act) words[beat] <= wdata;
    if (act && beat == beat_t'(1)) base <= addr;
  end

  assign busy   = act;
  // The last word is still on the input bus during the final beat.
  assign fwd_ok = act && (beat == LAST);

  always_comb begin
    fwd_words = words;
    fwd_words[BURST-1] = wdata;
  end
endmodule

// File: rtl/sbr_rd_pipe.sv
`timescale 1ns/1ps
module sbr_rd_pipe import sbr_pkg::*; #(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      lat_mode,
  input  logic                      acc,
  input  logic [AW-1:0]             addr,
  input  logic [BURST-1:0][DW-1:0]  bank_q,
  input  logic                      fwd_ok,
  input  logic [AW-1:0]             fwd_base,
  input  logic [BURST-1:0][DW-1:0]  fwd_words,
  output logic                      bank_re,
  output logic [AW-1:0]             bank_ra,
  output logic                      busy,
  output logic [DW-1:0]             rdata,
  output logic                      rvalid
);
  localparam int SHW = BURST + 2;

  logic [SHW-1:0]            sh;
  logic [AW-1:0]             ra_q;
  logic                      hit;
  logic [BURST-1:0][DW-1:0]  fwd_q, hold_q, pick;
  logic [BURST-1:0]          vsel;
  logic [DW-1:0]             nxt;

  // Token shift: sh[j] high means a read was accepted j+1 beats ago.
  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[SHW-2:0], acc};
  end

  always_ff @(posedge clk) begin
    if (acc) ra_q <= addr;
  end

  // Forwarding snapshot, taken on the beat the banks are read.
  always_ff @(posedge clk) begin
    if (sh[0]) begin
      hit   <= fwd_ok && (fwd_base == ra_q);
      fwd_q <= fwd_words;
    end
  end

  assign bank_re = sh[0];
  assign bank_ra = ra_q;
  assign busy    = sh[1];

  for (genvar g = 0; g < BURST; g++) begin : g_pick
    assign pick[g] = hit ? fwd_q[g] : bank_q[g];
  end

  always_ff @(posedge clk) begin
    if (sh[1]) hold_q <= pick;
  end

  assign vsel = lat_mode ? sh[BURST+1:2] : sh[BURST:1];

  always_comb begin
    nxt = '0;
    for (int w = 0; w < BURST; w++) begin
      if (vsel[w]) nxt = (w == 0 && !lat_mode) ? pick[0] : hold_q[w];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rdata  <= nxt;
      rvalid <= |vsel;
    end
  end

  assert_idle_zero_R9: assert property (@(posedge clk) disable iff (rst)
    !rvalid |-> rdata == '0);
  assert_lat_short_R5: assert property (@(posedge clk) disable iff (rst)
    (acc && !lat_mode) |-> ##3 rvalid);
  assert_lat_long_R5: assert property (@(posedge clk) disable iff (rst)
    (acc && lat_mode) |-> ##4 rvalid);
endmodule

// File: rtl/splitport_burst_ram.sv
`timescale 1ns/1ps
module splitport_burst_ram import sbr_pkg::*; #(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          lat_mode,
  input  logic          rd_sel_n,
  input  logic          wr_sel_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          rvalid
);
  logic                      ph;
  logic                      rd_acc, wr_acc, rd_busy, wr_busy;
  logic                      commit, fwd_ok, bank_re;
  logic [AW-1:0]             cbase, bank_ra;
  logic [BURST-1:0][DW-1:0]  cwords, fwords, bank_q;

  // Beat phase: 0 on the first beat of each command cycle.
  always_ff @(posedge clk) begin
    if (rst) ph <= 1'b0;
    else     ph <= ~ph;
  end

  assign rd_acc = !rst && !ph && !rd_sel_n && !rd_busy;
  assign wr_acc = !rst && !ph && !wr_sel_n && !wr_busy;

  sbr_wr_capture #(.AW(AW), .DW(DW)) u_wr (
    .clk(clk), .rst(rst), .acc(wr_acc), .addr(addr), .wdata(wdata),
    .busy(wr_busy), .commit(commit), .base(cbase), .words(cwords),
    .fwd_ok(fwd_ok), .fwd_words(fwords)
  );

  for (genvar g = 0; g < BURST; g++) begin : g_bank
    sbr_bank #(.AW(AW), .DW(DW)) u_bank (
      .clk(clk), .we(commit), .wa(cbase), .wd(cwords[g]),
      .re(bank_re), .ra(bank_ra), .q(bank_q[g])
    );
  end

  sbr_rd_pipe #(.AW(AW), .DW(DW)) u_rd (
    .clk(clk), .rst(rst), .lat_mode(lat_mode), .acc(rd_acc), .addr(addr),
    .bank_q(bank_q), .fwd_ok(fwd_ok), .fwd_base(cbase), .fwd_words(fwords),
    .bank_re(bank_re), .bank_ra(bank_ra), .busy(rd_busy),
    .rdata(rdata), .rvalid(rvalid)
  );

  assert_rd_gap_R6: assert property (@(posedge clk) disable iff (rst)
    rd_acc |-> !$past(rd_acc, 2));
  assert_wr_gap_R6: assert property (@(posedge clk) disable iff (rst)
    wr_acc |-> !$past(wr_acc, 2));
  assert_commit_after_four_R3: assert property (@(posedge clk) disable iff (rst)
    wr_acc |-> ##4 commit);
endmodule

// File: tb/tb_splitport_burst_ram.sv
`timescale 1ns/1ps
module tb_splitport_burst_ram;
  localparam int AW = 6;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          lat_mode = 1'b0;
  logic          rd_sel_n = 1'b1;
  logic          wr_sel_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          rvalid;

  always #2.5 clk = ~clk;

  splitport_burst_ram #(.AW(AW), .DW(DW)) dut (
    .clk(clk), .rst(rst), .lat_mode(lat_mode), .rd_sel_n(rd_sel_n),
    .wr_sel_n(wr_sel_n), .addr(addr), .wdata(wdata),
    .rdata(rdata), .rvalid(rvalid)
  );

  int    n_cmp = 0;
  int    n_bad = 0;
  bit    started = 0;
  bit    done = 0;
  string cur_req = "R1";

  // ---------------- behavioural reference model ----------------
  logic [DW-1:0] mdl_mem [int];
  logic [DW-1:0] sched [int];
  logic [DW-1:0] m_wbuf [4];
  int  cyc, m_wleft, m_widx, m_wbase, m_rlast, m_rbase, m_rfetch;
  bit  m_ph;
  bit  exp_v;
  logic [DW-1:0] exp_d;

  always @(posedge clk) begin
    started <= 1'b1;
    if (rst) begin
      cyc = 0; m_ph = 0; m_wleft = 0; m_widx = 0;
      m_rlast = -100; m_rfetch = -1;
      sched.delete();
      exp_v = 0; exp_d = '0;
    end else begin
      if (sched.exists(cyc)) begin
        exp_v = 1; exp_d = sched[cyc]; sched.delete(cyc);
      end else begin
        exp_v = 0; exp_d = '0;
      end
      if (!m_ph) begin
        if (!wr_sel_n && m_wleft == 0) begin m_wleft = 4; m_widx = 0; end
        if (!rd_sel_n && (cyc - m_rlast) >= 4) begin
          m_rlast = cyc; m_rbase = int'(addr); m_rfetch = cyc + 1;
        end
      end
      if (m_wleft > 0) begin
        m_wbuf[m_widx] = wdata;
        if (m_widx == 1) m_wbase = int'(addr);
        if (m_widx == 3)
          for (int k = 0; k < 4; k++) mdl_mem[m_wbase*4 + k] = m_wbuf[k];
        m_widx++; m_wleft--;
      end
      if (cyc == m_rfetch)
        for (int k = 0; k < 4; k++)
          sched[cyc - 1 + (lat_mode ? 3 : 2) + k] = mdl_mem[m_rbase*4 + k];
      m_ph = ~m_ph;
      cyc++;
    end
  end

  // ---------------- compare on every beat ----------------
  always @(negedge clk) begin
    if (started && !done) begin
      n_cmp++;
      if (rvalid !== exp_v || rdata !== exp_d) begin
        n_bad++;
        $display("FAIL %s: rvalid/rdata = %0b/%h expected %0b/%h", cur_req,
                 rvalid, rdata, exp_v, exp_d);
      end
    end
  end

  // ---------------- stimulus ----------------
  bit            wpend = 0;
  logic [DW-1:0] wp2, wp3;

  // Entered at a negedge just before a beat-0 edge; leaves at the same point.
  task automatic cmd(input bit rd, input int ra, input bit wr, input int wa,
                     input int seed);
    logic [DW-1:0] d0, d1;
    d0 = DW'(seed); d1 = DW'(seed + 1);
    rd_sel_n = !rd; wr_sel_n = !wr; addr = AW'(ra);
    wdata = wpend ? wp2 : (wr ? d0 : '0);
    @(negedge clk);
    rd_sel_n = 1'b1; wr_sel_n = 1'b1; addr = AW'(wa);
    wdata = wpend ? wp3 : (wr ? d1 : '0);
    if (wpend) wpend = 0;
    else if (wr) begin wpend = 1; wp2 = DW'(seed + 2); wp3 = DW'(seed + 3); end
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cmd(0, 0, 0, 0, 0);
  endtask

  task automatic do_reset(input bit mode);
    rst = 1'b1; rd_sel_n = 1'b1; wr_sel_n = 1'b1; wdata = '0; wpend = 0;
    lat_mode = mode;
    repeat (4) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic run_suite(input int salt);
    cur_req = "R2/R3/R4";
    cmd(0, 0, 1, 1, salt + 16'h1100);
    cmd(0, 0, 0, 0, 0);
    cmd(0, 0, 1, 2, salt + 16'h2200);
    cmd(0, 0, 0, 0, 0);
    cmd(0, 0, 1, 3, salt + 16'h3300);
    cmd(0, 0, 0, 0, 0);
    cmd(0, 0, 1, 5, salt + 16'h5500);
    idle(3);
    cmd(1, 1, 0, 0, 0); idle(2);
    cmd(1, 3, 0, 0, 0); cmd(0, 0, 0, 0, 0);
    cmd(1, 2, 0, 0, 0); idle(3);
    cur_req = "R6";
    cmd(1, 1, 0, 0, 0); cmd(1, 2, 0, 0, 0);
    cmd(1, 3, 0, 0, 0); cmd(1, 5, 0, 0, 0);
    idle(3);
    cmd(0, 0, 1, 4, salt + 16'h4400);
    cmd(0, 0, 1, 5, salt + 16'h7700);
    idle(2);
    cmd(1, 5, 0, 0, 0); cmd(0, 0, 0, 0, 0);
    cmd(1, 4, 0, 0, 0); idle(3);
    cur_req = "R7";
    cmd(1, 2, 1, 2, salt + 16'h6600);
    idle(3);
    cmd(1, 2, 0, 0, 0); idle(3);
    cur_req = "R8";
    cmd(0, 0, 1, 3, salt + 16'h8800);
    cmd(1, 3, 0, 0, 0);
    idle(3);
    cur_req = "R9";
    idle(4);
  endtask

  initial begin
    cur_req = "R1";
    do_reset(1'b0);
    idle(2);
    cur_req = "R5 short";
    run_suite(16'h0000);
    cur_req = "R10";
    cmd(0, 0, 1, 1, 16'hdd00);
    do_reset(1'b0);
    wpend = 0;
    cmd(1, 1, 0, 0, 0); idle(4);
    cur_req = "R1";
    do_reset(1'b1);
    cmd(1, 4, 0, 0, 0); idle(4);
    cur_req = "R5 long";
    run_suite(16'h0040);
    cur_req = "R10";
    cmd(0, 0, 1, 2, 16'hee00);
    cmd(0, 0, 0, 0, 0);
    do_reset(1'b1);
    cmd(1, 2, 0, 0, 0); idle(4);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule